// File: doc/BRIEF.md
# ADC System Calibration Sequencer

This block runs system calibration on an external converter from the host side. A one-cycle start request latches a calibration mode and a repeat count. The controller then steps through the calibration phases. For each phase it steers a level-select line that tells the analog front end to present either the offset reference or the full-scale reference. It waits a programmable settling interval, then drives a programmable-width low pulse on one of two active-low strobes: the calibration strobe or the conversion-start strobe. After that it follows the converter's BUSY handshake through a two-flop synchronizer until the phase ends.

There are three modes. The split mode runs an offset pass and then a gain pass, with each phase opened by a calibration strobe. The merged mode runs gain first and offset second: the gain phase opens with a calibration strobe, and the offset phase opens with a conversion-start strobe, which is only sent after BUSY has dropped. The full mode uses the same order as the merged mode, but its first phase also covers the converter's internal DAC step, so the allowed BUSY time for that phase is eight times longer. The pass sequence repeats one to three times. A one-cycle done pulse follows the last phase. A BUSY that never rises, or never falls, sets a sticky error and returns the controller to idle.

Top module: `cal_seq_ctrl`

## Requirements
- R1: Out of reset both strobes are high, and level-select, done, error and run are all low.
- R2: The mode and the repeat count are captured only when start is seen while idle. Start, mode and repeat inputs that change during a run have no effect on the sequence.
- R3: The level of each phase appears on the level-select line at phase entry. The strobe falls exactly max(S,1) cycles after the start request is accepted, where S is the settle setting.
- R4: Every strobe low pulse lasts exactly max(P,1) cycles, where P is the pulse setting.
- R5: Mode 2'b00 (split) runs each pass as an offset phase (level-select 0) followed by a gain phase (level-select 1). Both phases use the calibration strobe, and the conversion-start strobe never pulses in this mode.
- R6: Modes 2'b01 (merged), 2'b10 and 2'b11 (full) run each pass as a gain phase (level-select 1, calibration strobe) followed by an offset phase (level-select 0, conversion-start strobe). The conversion-start strobe is low only while BUSY is low.
- R7: The number of passes equals the latched repeat count, with a count of 0 treated as 1.
- R8: The level-select output does not change from the strobe of a phase until BUSY has fallen for that phase.
- R9: If synchronized BUSY is not high within 8 cycles after a strobe rises, the error flag sets. The run then ends with both strobes high and no done pulse.
- R10: If synchronized BUSY stays high for the fall limit L, the error flag sets. The limit is 8·L for the first phase of a pass in full mode.
- R11: Done is high for exactly one cycle after the last phase, and run drops on the next cycle. A new accepted start clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted while idle |
| mode_i | input | 2 | Calibration mode: 00 split, 01 merged, 10/11 full |
| repeat_i | input | 2 | Pass count 1..3 (0 treated as 1) |
| settle_i | input | TW | Settling cycles before each strobe |
| pulse_i | input | TW | Strobe low width in cycles |
| busy_limit_i | input | LIM_W | Maximum synchronized BUSY high cycles |
| busy_i | input | 1 | Converter BUSY, asynchronous |
| cal_n_o | output | 1 | Active-low calibration strobe |
| convst_n_o | output | 1 | Active-low conversion-start strobe |
| lvl_full_o | output | 1 | Level select: 1 full-scale, 0 offset |
| run_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout error |

## Verification
The in-RTL assertions check the following on every cycle:
- the level select stays stable while a phase waits on BUSY;
- a strobe only falls after a settle interval;
- a conversion-start pulse only starts with synchronized BUSY low;
- the pass counter stays within the latched count;
- done is a single pulse;
- the error flag only rises from a wait state.

Other behaviour only shows up in the bench's scenarios against a converter model:
- the exact phase order and level per mode;
- the number of strobes that follows from the repeat clamp;
- the measured settle and pulse widths;
- the long first-phase limit in full mode;
- the two timeout paths.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'b00,
        MODE_MERGED = 2'b01,
        MODE_FULL   = 2'b10,
        MODE_FULL2  = 2'b11
    } cal_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SETTLE    = 3'd1,
        ST_STROBE    = 3'd2,
        ST_WAIT_RISE = 3'd3,
        ST_WAIT_FALL = 3'd4,
        ST_DONE      = 3'd5
    } cal_state_e;

    typedef enum logic {
        STB_CAL  = 1'b0,
        STB_CONV = 1'b1
    } strobe_e;

endpackage

// File: rtl/cal_busy_sync.sv
module cal_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/cal_phase_map.sv
module cal_phase_map
    import cal_seq_pkg::*;
(
    input  cal_mode_e mode_i,
    input  logic      phase_i,
    output strobe_e   strobe_o,
    output logic      lvl_full_o,
    output logic      long_o
);
    always_comb begin
        if (mode_i == MODE_SPLIT) begin
            strobe_o   = STB_CAL;
            lvl_full_o = phase_i;
            long_o     = 1'b0;
        end else begin
            strobe_o   = phase_i ? STB_CONV : STB_CAL;
            lvl_full_o = !phase_i;
            long_o     = mode_i[1] && !phase_i;
        end
    end
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
    import cal_seq_pkg::*;
#(
    parameter int TW          = 8,
    parameter int LIM_W       = 16,
    parameter int RISE_WIN    = 8,
    parameter int LONG_SH     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       repeat_i,
    input  logic [TW-1:0]    settle_i,
    input  logic [TW-1:0]    pulse_i,
    input  logic [LIM_W-1:0] busy_limit_i,
    input  logic             busy_i,
    output logic             cal_n_o,
    output logic             convst_n_o,
    output logic             lvl_full_o,
    output logic             run_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int CW = LIM_W + LONG_SH;

    typedef struct packed {
        cal_state_e    st;
        cal_mode_e     mode;
        logic [1:0]    reps;
        logic [1:0]    pass;
        logic          phase;
        logic [CW-1:0] cnt;
        logic          lvl;
        logic          err;
    } regs_t;

    regs_t r_q, r_d;

    logic          busy_s;
    strobe_e       map_stb;
    logic          map_lvl;
    logic          map_long;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] lim_eff;

    cal_busy_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (busy_i),
        .sync_o  (busy_s)
    );

    cal_phase_map i_map (
        .mode_i     (r_q.mode),
        .phase_i    (r_q.phase),
        .strobe_o   (map_stb),
        .lvl_full_o (map_lvl),
        .long_o     (map_long)
    );

    assign cnt_inc = r_q.cnt + CW'(1);
    assign lim_eff = map_long ? (CW'(busy_limit_i) << LONG_SH) : CW'(busy_limit_i);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.mode  = cal_mode_e'(mode_i);
                    r_d.reps  = (repeat_i == 2'd0) ? 2'd1 : repeat_i;
                    r_d.pass  = 2'd1;
                    r_d.phase = 1'b0;
                    r_d.cnt   = '0;
                    r_d.err   = 1'b0;
                    r_d.st    = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                r_d.lvl = map_lvl;
                if (cnt_inc >= CW'(settle_i)) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_STROBE;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_STROBE: begin
                if (cnt_inc >= CW'(pulse_i)) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_WAIT_RISE;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_WAIT_RISE: begin
                if (busy_s) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_WAIT_FALL;
                end else if (cnt_inc >= CW'(RISE_WIN)) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_WAIT_FALL: begin
                if (!busy_s) begin
                    r_d.cnt = '0;
                    if (!r_q.phase) begin
                        r_d.phase = 1'b1;
                        r_d.st    = ST_SETTLE;
                    end else if (r_q.pass == r_q.reps) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.pass  = r_q.pass + 2'd1;
                        r_d.phase = 1'b0;
                        r_d.st    = ST_SETTLE;
                    end
                end else if (cnt_inc >= lim_eff) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.cnt = cnt_inc;
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: MODE_SPLIT, reps: 2'd1, pass: 2'd1,
                     phase: 1'b0, cnt: '0, lvl: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cal_n_o    = !(r_q.st == ST_STROBE && map_stb == STB_CAL);
    assign convst_n_o = !(r_q.st == ST_STROBE && map_stb == STB_CONV);
    assign lvl_full_o = (r_q.st == ST_SETTLE) ? map_lvl : r_q.lvl;
    assign run_o      = (r_q.st != ST_IDLE);
    assign done_o     = (r_q.st == ST_DONE);
    assign err_o      = r_q.err;

    // R8
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_RISE || r_q.st == ST_WAIT_FALL) |-> $stable(lvl_full_o));

    // R3
    strobe_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cal_n_o) || $fell(convst_n_o)) |-> $past(r_q.st) == ST_SETTLE);

    // R6
    conv_busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst_n_o) |-> !busy_s);

    // R7
    pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (r_q.pass != 2'd0 && r_q.pass <= r_q.reps));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !run_o));

    // R9
    err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!run_o && ($past(r_q.st) == ST_WAIT_RISE ||
                                     $past(r_q.st) == ST_WAIT_FALL)));
endmodule

// File: tb/test_cal_seq_ctrl.sv
module test_cal_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [1:0]  repeat_i = 2'd1;
    logic [7:0]  settle_i = 8'd1;
    logic [7:0]  pulse_i = 8'd1;
    logic [15:0] busy_limit_i = 16'd40;
    logic        busy_i;
    logic        cal_n_o, convst_n_o, lvl_full_o, run_o, done_o, err_o;

    cal_seq_ctrl i_cal_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .repeat_i(repeat_i), .settle_i(settle_i), .pulse_i(pulse_i),
        .busy_limit_i(busy_limit_i), .busy_i(busy_i), .cal_n_o(cal_n_o),
        .convst_n_o(convst_n_o), .lvl_full_o(lvl_full_o), .run_o(run_o),
        .done_o(done_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // converter model: BUSY answers each strobe rising edge
    logic        m_clr = 1'b0;
    int          m_bf = 10, m_bl = 10;
    int          m_idx = 0, m_dly = 0, m_len = 0;
    logic        m_prev = 1'b1;
    logic        m_busy = 1'b0;
    assign busy_i = m_busy;

    always @(negedge clk) begin
        logic both;
        int   dur;
        both = cal_n_o & convst_n_o;
        if (m_clr) begin
            m_idx = 0;
        end else if (both && !m_prev) begin
            dur = m_idx[0] ? m_bl : m_bf;
            m_idx = m_idx + 1;
            if (dur != 0) begin
                m_dly = 2;
                m_len = dur;
            end
        end else if (m_dly != 0) begin
            m_dly = m_dly - 1;
            if (m_dly == 0) m_busy = 1'b1;
        end else if (m_busy) begin
            m_len = m_len - 1;
            if (m_len == 0) m_busy = 1'b0;
        end
        m_prev = both;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  rep;
        logic [7:0]  s;
        logic [7:0]  p;
        logic [15:0] bf;
        logic [15:0] bl;
        logic [15:0] lim;
        logic [3:0]  ecal;
        logic [3:0]  ecv;
        logic        eerr;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd1, 8'd3, 8'd2, 16'd10,  16'd10, 16'd40, 4'd2, 4'd0, 1'b0},
        '{2'd0, 2'd2, 8'd1, 8'd1, 16'd12,  16'd8,  16'd40, 4'd4, 4'd0, 1'b0},
        '{2'd0, 2'd0, 8'd0, 8'd0, 16'd6,   16'd6,  16'd40, 4'd2, 4'd0, 1'b0},
        '{2'd1, 2'd1, 8'd2, 8'd3, 16'd10,  16'd10, 16'd40, 4'd1, 4'd1, 1'b0},
        '{2'd1, 2'd3, 8'd4, 8'd1, 16'd9,   16'd14, 16'd40, 4'd3, 4'd3, 1'b0},
        '{2'd2, 2'd2, 8'd2, 8'd2, 16'd100, 16'd20, 16'd40, 4'd2, 4'd2, 1'b0},
        '{2'd3, 2'd1, 8'd1, 8'd2, 16'd100, 16'd20, 16'd40, 4'd1, 4'd1, 1'b0},
        '{2'd1, 2'd1, 8'd2, 8'd2, 16'd100, 16'd20, 16'd40, 4'd1, 4'd0, 1'b1},
        '{2'd0, 2'd1, 8'd2, 8'd2, 16'd0,   16'd10, 16'd40, 4'd1, 4'd0, 1'b1},
        '{2'd0, 2'd1, 8'd2, 8'd2, 16'd10,  16'd0,  16'd40, 4'd2, 4'd0, 1'b1},
        '{2'd1, 2'd2, 8'd5, 8'd4, 16'd30,  16'd30, 16'd40, 4'd2, 4'd2, 1'b0}
    };

    task automatic run_vec(input vec_t v, input bit disturb);
        int  settle_cnt = 0, cur_w = 0, pw_bad = 0, n_cal = 0, n_cv = 0;
        int  ord_bad = 0, hold_bad = 0, cvb_bad = 0, done_cnt = 0, idx = 0, guard = 0;
        int  exp_s, exp_p;
        bit  seen = 0, prev_low = 0, rec_lvl = 0, low, kind, exp_kind, exp_lvl;
        exp_s = (v.s == 0) ? 1 : int'(v.s);
        exp_p = (v.p == 0) ? 1 : int'(v.p);
        @(negedge clk);
        mode_i = v.mode; repeat_i = v.rep; settle_i = v.s; pulse_i = v.p;
        busy_limit_i = v.lim; m_bf = int'(v.bf); m_bl = int'(v.bl);
        m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R11: accepted start clears a previous error
        chk(!err_o && run_o, "R11 err cleared on start", int'(err_o), 0);
        while (run_o && guard < 5000) begin
            low = !cal_n_o || !convst_n_o;
            if (!seen && !low) settle_cnt++;
            if (low) begin
                cur_w++;
                if (!prev_low) begin
                    seen = 1;
                    kind = !convst_n_o;
                    if (v.mode == 2'd0) begin
                        exp_kind = 1'b0; exp_lvl = idx[0];
                    end else begin
                        exp_kind = idx[0]; exp_lvl = !idx[0];
                    end
                    if (kind != exp_kind || lvl_full_o != exp_lvl) ord_bad++;
                    rec_lvl = lvl_full_o;
                    if (kind) n_cv++; else n_cal++;
                    idx++;
                end
            end else if (prev_low) begin
                if (cur_w != exp_p) pw_bad++;
                cur_w = 0;
            end
            if (m_busy && idx > 0 && lvl_full_o != rec_lvl) hold_bad++;
            if (!convst_n_o && m_busy) cvb_bad++;
            if (done_o) done_cnt++;
            prev_low = low;
            guard++;
            if (disturb && guard == 3) begin
                mode_i = 2'd0; repeat_i = 2'd3; start_i = 1'b1;
            end
            if (disturb && guard == 4) start_i = 1'b0;
            @(negedge clk);
        end
        chk(guard < 5000, "R11 run ends", guard, 5000);
        chk(settle_cnt == exp_s, "R3 settle cycles", settle_cnt, exp_s);
        chk(pw_bad == 0, "R4 pulse width", pw_bad, 0);
        chk(n_cal == int'(v.ecal), "R7 calibration strobes", n_cal, int'(v.ecal));
        chk(n_cv == int'(v.ecv), "R6 conversion strobes", n_cv, int'(v.ecv));
        chk(ord_bad == 0, "R5 R6 phase order and level", ord_bad, 0);
        chk(hold_bad == 0, "R8 level held while busy", hold_bad, 0);
        chk(cvb_bad == 0, "R6 conversion strobe with busy low", cvb_bad, 0);
        chk(err_o == v.eerr, "R9 R10 error flag", int'(err_o), int'(v.eerr));
        chk(done_cnt == (v.eerr ? 0 : 1), "R11 done pulse count", done_cnt, v.eerr ? 0 : 1);
        chk(cal_n_o && convst_n_o, "R9 strobes idle high", int'(cal_n_o & convst_n_o), 1);
        guard = 0;
        while (m_busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cal_n_o && convst_n_o, "R1 strobes high", int'(cal_n_o & convst_n_o), 1);
        chk(!lvl_full_o && !done_o && !err_o && !run_o, "R1 outputs low",
            int'({lvl_full_o, done_o, err_o, run_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!run_o && cal_n_o, "R1 idle after reset", int'(run_o), 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

        // R2: mode, repeat and start changes during a run are ignored
        run_vec('{2'd1, 2'd1, 8'd2, 8'd2, 16'd10, 16'd10, 16'd40, 4'd1, 4'd1, 1'b0}, 1'b1);

        // R10: same long first phase passes only under full mode
        run_vec('{2'd2, 2'd1, 8'd1, 8'd1, 16'd200, 16'd10, 16'd30, 4'd1, 4'd1, 1'b0}, 1'b0);
        run_vec('{2'd1, 2'd1, 8'd1, 8'd1, 16'd200, 16'd10, 16'd30, 4'd1, 4'd0, 1'b1}, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule